// File: doc/BRIEF.md
# Register vectorisation tag table

The block keeps one tag per scalar register number for an issue stage. A tag says whether the register is treated as a vector and whether it is packed (SIMD), which register bank it uses, and whether the tag is in force at all. There are two dense tables, one for the integer file and one for the floating-point file, with 32 entries each. Software does not write these tables directly. It writes up to sixteen sparse configuration slots. Each slot names a file, a register key and the attributes for that register.

A single-cycle commit pulse rebuilds both tables from the slots. The rebuild first wipes every entry, then applies the slots one per cycle from the lowest index to the highest. When two slots name the same register, the later slot therefore overwrites the earlier one. A slot that asks for a reserved bank is dropped, and a sticky error flag records it.

A combinational lookup port returns the tag for a given file and register number. While a rebuild runs, the lookup returns an all-zero (disabled) tag, and slot writes and further commits are refused.

Top module: `regtag_table`

## Requirements
- R1: After reset, busy_o and bank_err_o are 0 and every lookup in both files returns an all-zero tag.
- R2: A commit_i pulse taken while idle raises busy_o on the next cycle, and busy_o stays high for exactly 17 cycles: one wipe cycle, then one cycle per slot.
- R3: A rebuild zeroes every entry of both tables before it applies any slot. After it, a register named by no applied slot reads all zero, even if an earlier rebuild had set it.
- R4: A slot whose file bit is 0 writes the integer table and a slot whose file bit is 1 writes the floating-point table, at the entry selected by its 5-bit register key. The other table is untouched. lk_file_i uses the same encoding.
- R5: An applied entry reads back with lk_enabled_o=1 and with lk_vec_o, lk_packed_o and lk_bank_o equal to the slot's vector flag, packed flag and bank field.
- R6: Bank value 0 is the only valid bank. A used slot with any non-zero bank is not applied and sets bank_err_o. bank_err_o stays at 1 until reset.
- R7: When several used slots name the same register in the same file, the slot with the highest index determines the tag.
- R8: While busy_o is 1, every lookup returns an all-zero tag.
- R9: A slot write or a commit pulse presented while busy_o is 1 is ignored. It changes neither the rebuild length nor the tables that result.
- R10: A slot write and a commit presented in the same idle cycle are both taken, and the rebuild uses the newly written slot.
- R11: A slot written with cfg_used_i=0 is skipped by the rebuild, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Slot write strobe |
| cfg_slot_i | input | 4 | Index of the slot to write |
| cfg_used_i | input | 1 | Slot takes part in rebuilds |
| cfg_file_i | input | 1 | Target file: 0 integer, 1 floating point |
| cfg_key_i | input | 5 | Register key |
| cfg_vec_i | input | 1 | Vector flag |
| cfg_packed_i | input | 1 | Packed (SIMD) flag |
| cfg_bank_i | input | 2 | Bank field; only 0 is valid |
| commit_i | input | 1 | Single-cycle pulse that starts a rebuild |
| busy_o | output | 1 | Rebuild in progress |
| bank_err_o | output | 1 | Sticky flag: a slot with a reserved bank was dropped |
| lk_file_i | input | 1 | Lookup file: 0 integer, 1 floating point |
| lk_reg_i | input | 5 | Lookup register number |
| lk_enabled_o | output | 1 | Tag is in force |
| lk_vec_o | output | 1 | Tag vector flag |
| lk_packed_o | output | 1 | Tag packed flag |
| lk_bank_o | output | 2 | Tag bank |

## Verification
Two pairs of events can land in the same cycle. The first pair is a slot write and the commit that starts a rebuild. The bench issues both on one idle cycle and judges the result by whether the rebuilt table shows the newly written slot. The second pair is a rebuild in progress together with new configuration traffic. The bench presents a slot write and a second commit in the middle of a rebuild. It then checks that the busy window still closes after 17 cycles and that the table sweep afterwards holds no trace of the refused write. A behavioural model that rebuilds its tables from plain arrays is compared with busy_o, the error flag and the lookup outputs on every cycle, and each rebuild is followed by a sweep of all 64 registers.

// File: rtl/regtag_pkg.sv
package regtag_pkg;
  localparam int NUM_SLOTS = 16;
  localparam int NUM_REGS  = 32;
  localparam int NUM_FILES = 2;
  localparam int BANK_W    = 2;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int REG_W     = $clog2(NUM_REGS);
  localparam int STEP_W    = $clog2(NUM_SLOTS + 1);

  typedef struct packed {
    logic              en;
    logic              vec;
    logic              packd;
    logic [BANK_W-1:0] bank;
  } tag_t;

  typedef struct packed {
    logic              used;
    logic              file;
    logic [REG_W-1:0]  key;
    logic              vec;
    logic              packd;
    logic [BANK_W-1:0] bank;
  } slot_t;
endpackage

// File: rtl/regtag_slots.sv
module regtag_slots
  import regtag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] wr_idx_i,
  input  slot_t             wr_slot_i,
  input  logic [SLOT_W-1:0] rd_idx_i,
  output slot_t             rd_slot_o
);
  slot_t slot_q [NUM_SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SLOTS; i++) slot_q[i] <= '0;
    end else if (we_i) begin
      slot_q[wr_idx_i] <= wr_slot_i;
    end
  end

  assign rd_slot_o = slot_q[rd_idx_i];
endmodule

// File: rtl/regtag_seq.sv
module regtag_seq
  import regtag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              clear_o,
  output logic              apply_o,
  output logic [SLOT_W-1:0] slot_idx_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_SLOTS);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;

  // step 0 wipes, steps 1..NUM_SLOTS apply slot step-1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end
    end else if (step_q == LAST_STEP) begin
      busy_q <= 1'b0;
    end else begin
      step_q <= step_q + STEP_W'(1);
    end
  end

  logic [STEP_W-1:0] idx_w;
  assign idx_w      = step_q - STEP_W'(1);
  assign busy_o     = busy_q;
  assign clear_o    = busy_q && (step_q == '0);
  assign apply_o    = busy_q && (step_q != '0);
  assign slot_idx_o = idx_w[SLOT_W-1:0];
endmodule

// File: rtl/regtag_array.sv
module regtag_array
  import regtag_pkg::*;
#(
  parameter bit FILE_SEL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             apply_i,
  input  slot_t            slot_i,
  input  logic [REG_W-1:0] rd_idx_i,
  output tag_t             rd_tag_o
);
  tag_t ent_q [NUM_REGS];
  logic hit;

  assign hit = apply_i && slot_i.used && (slot_i.file == FILE_SEL) && (slot_i.bank == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) ent_q[i] <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < NUM_REGS; i++) ent_q[i] <= '0;
    end else if (hit) begin
      ent_q[slot_i.key] <= '{en: 1'b1, vec: slot_i.vec, packd: slot_i.packd, bank: slot_i.bank};
    end
  end

  assign rd_tag_o = ent_q[rd_idx_i];
endmodule

// File: rtl/regtag_table.sv
module regtag_table
  import regtag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic              cfg_used_i,
  input  logic              cfg_file_i,
  input  logic [REG_W-1:0]  cfg_key_i,
  input  logic              cfg_vec_i,
  input  logic              cfg_packed_i,
  input  logic [BANK_W-1:0] cfg_bank_i,
  input  logic              commit_i,
  output logic              busy_o,
  output logic              bank_err_o,
  input  logic              lk_file_i,
  input  logic [REG_W-1:0]  lk_reg_i,
  output logic              lk_enabled_o,
  output logic              lk_vec_o,
  output logic              lk_packed_o,
  output logic [BANK_W-1:0] lk_bank_o
);
  logic              busy, clear, apply;
  logic [SLOT_W-1:0] cur_idx;
  slot_t             wr_slot, cur_slot;
  tag_t              rd_tag [NUM_FILES];
  tag_t              lk_tag;
  logic              err_q;

  assign wr_slot = '{used: cfg_used_i, file: cfg_file_i, key: cfg_key_i,
                     vec: cfg_vec_i, packd: cfg_packed_i, bank: cfg_bank_i};

  regtag_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (commit_i),
    .busy_o     (busy),
    .clear_o    (clear),
    .apply_o    (apply),
    .slot_idx_o (cur_idx)
  );

  regtag_slots u_slots (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i && !busy),
    .wr_idx_i  (cfg_slot_i),
    .wr_slot_i (wr_slot),
    .rd_idx_i  (cur_idx),
    .rd_slot_o (cur_slot)
  );

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    regtag_array #(.FILE_SEL(f[0])) u_arr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (clear),
      .apply_i  (apply),
      .slot_i   (cur_slot),
      .rd_idx_i (lk_reg_i),
      .rd_tag_o (rd_tag[f])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          err_q <= 1'b0;
    else if (apply && cur_slot.used && cur_slot.bank != '0) err_q <= 1'b1;
  end

  assign lk_tag       = busy ? '0 : rd_tag[lk_file_i];
  assign busy_o       = busy;
  assign bank_err_o   = err_q;
  assign lk_enabled_o = lk_tag.en;
  assign lk_vec_o     = lk_tag.vec;
  assign lk_packed_o  = lk_tag.packd;
  assign lk_bank_o    = lk_tag.bank;
endmodule

// File: rtl/regtag_table_chk.sv
module regtag_table_chk
  import regtag_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              commit_i,
  input logic              busy_o,
  input logic              bank_err_o,
  input logic              lk_enabled_o,
  input logic [BANK_W-1:0] lk_bank_o
);
  localparam int LEN = NUM_SLOTS + 1;
  logic [STEP_W:0] busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len_q <= '0;
    else if (busy_o) busy_len_q <= busy_len_q + 1'b1;
    else             busy_len_q <= '0;
  end

  AST_COMMIT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && commit_i) |=> busy_o); // R2
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len_q == (STEP_W+1)'(LEN))); // R2
  AST_BUSY_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_len_q <= (STEP_W+1)'(LEN)); // R9
  AST_BUSY_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !lk_enabled_o); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_err_o |=> bank_err_o); // R6
  AST_BANK_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_enabled_o |-> (lk_bank_o == '0)); // R6
endmodule

bind regtag_table regtag_table_chk u_chk (.*);

// File: tb/regtag_table_test.sv
`timescale 1ns/1ps
module regtag_table_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [3:0] cfg_slot_i = '0;
  logic       cfg_used_i = 1'b0;
  logic       cfg_file_i = 1'b0;
  logic [4:0] cfg_key_i = '0;
  logic       cfg_vec_i = 1'b0;
  logic       cfg_packed_i = 1'b0;
  logic [1:0] cfg_bank_i = '0;
  logic       commit_i = 1'b0;
  logic       busy_o, bank_err_o;
  logic       lk_file_i = 1'b0;
  logic [4:0] lk_reg_i = '0;
  logic       lk_enabled_o, lk_vec_o, lk_packed_o;
  logic [1:0] lk_bank_o;

  always #10 clk_i = ~clk_i;

  regtag_table uut (.*);

  int    total = 0, bad = 0;
  bit    done = 0;
  string ph = "R1";

  // behavioural model
  bit m_used[16], m_file[16], m_vec[16], m_pk[16];
  int m_key[16], m_bank[16];
  bit t_en[2][32], t_vec[2][32], t_pk[2][32];
  int t_bank[2][32];
  bit m_busy, m_err;
  int m_cnt;

  function automatic void rebuild();
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 32; r++) begin
        t_en[f][r] = 0; t_vec[f][r] = 0; t_pk[f][r] = 0; t_bank[f][r] = 0;
      end
    for (int s = 0; s < 16; s++) begin
      if (!m_used[s]) continue;
      if (m_bank[s] != 0) begin m_err = 1; continue; end
      t_en[m_file[s]][m_key[s]]   = 1;
      t_vec[m_file[s]][m_key[s]]  = m_vec[s];
      t_pk[m_file[s]][m_key[s]]   = m_pk[s];
      t_bank[m_file[s]][m_key[s]] = 0;
    end
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int s = 0; s < 16; s++) begin
        m_used[s] = 0; m_file[s] = 0; m_vec[s] = 0; m_pk[s] = 0; m_key[s] = 0; m_bank[s] = 0;
      end
      m_busy = 0; m_err = 0; m_cnt = 0;
      rebuild();
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin m_busy = 0; rebuild(); end
    end else begin
      if (cfg_we_i) begin
        m_used[cfg_slot_i] = cfg_used_i; m_file[cfg_slot_i] = cfg_file_i;
        m_key[cfg_slot_i] = int'(cfg_key_i); m_vec[cfg_slot_i] = cfg_vec_i;
        m_pk[cfg_slot_i] = cfg_packed_i; m_bank[cfg_slot_i] = int'(cfg_bank_i);
      end
      if (commit_i) begin m_busy = 1; m_cnt = 17; end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", ph, what, act, exp);
    end
  endtask

  task automatic compare();
    int f, r;
    f = int'(lk_file_i); r = int'(lk_reg_i);
    chk(busy_o == m_busy, "busy", busy_o, m_busy);
    if (!m_busy) chk(bank_err_o == m_err, "bank_err", bank_err_o, m_err);
    chk(lk_enabled_o == (m_busy ? 1'b0 : t_en[f][r]), "enabled", lk_enabled_o, m_busy ? 0 : t_en[f][r]);
    chk(lk_vec_o == (m_busy ? 1'b0 : t_vec[f][r]), "vec", lk_vec_o, m_busy ? 0 : t_vec[f][r]);
    chk(lk_packed_o == (m_busy ? 1'b0 : t_pk[f][r]), "packed", lk_packed_o, m_busy ? 0 : t_pk[f][r]);
    chk(int'(lk_bank_o) == (m_busy ? 0 : t_bank[f][r]), "bank", lk_bank_o, m_busy ? 0 : t_bank[f][r]);
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
  endtask

  task automatic wr(input int s, input bit u, input bit f, input int k,
                    input bit v, input bit p, input int b);
    cfg_we_i = 1; cfg_slot_i = 4'(s); cfg_used_i = u; cfg_file_i = f;
    cfg_key_i = 5'(k); cfg_vec_i = v; cfg_packed_i = p; cfg_bank_i = 2'(b);
    tick();
    cfg_we_i = 0;
  endtask

  task automatic commit_and_wait();
    commit_i = 1; tick(); commit_i = 0;
    for (int i = 0; i < 40 && m_busy; i++) begin
      lk_file_i = 1'(i); lk_reg_i = 5'(i * 7);
      tick();
    end
  endtask

  task automatic sweep();
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 32; r++) begin
        lk_file_i = 1'(f); lk_reg_i = 5'(r);
        tick();
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    ph = "R1"; compare(); sweep();

    ph = "R4"; // file bit 0 -> integer, 1 -> FP; R5 attributes copied
    wr(0, 1, 0, 3, 1, 0, 0);
    wr(1, 1, 1, 3, 0, 1, 0);
    wr(2, 1, 0, 31, 1, 1, 0);
    wr(3, 1, 1, 0, 0, 0, 0);
    ph = "R8"; commit_and_wait();
    ph = "R5"; sweep();

    ph = "R7"; // slot 5 overrides slot 0 on int reg 3
    wr(5, 1, 0, 3, 0, 1, 0);
    commit_and_wait(); sweep();

    ph = "R3"; // earlier entries must vanish
    for (int s = 0; s < 6; s++) wr(s, 0, 0, 0, 0, 0, 0);
    wr(6, 1, 0, 10, 1, 1, 0);
    commit_and_wait(); sweep();

    ph = "R11";
    wr(8, 0, 1, 20, 1, 1, 0);
    commit_and_wait(); sweep();

    ph = "R2";
    commit_i = 1; tick(); commit_i = 0;
    n = 0;
    while (busy_o && n < 40) begin n++; tick(); end
    chk(n == 17, "busy_len", n, 17);

    ph = "R9"; // write and commit mid-rebuild are refused
    commit_i = 1; tick(); commit_i = 0;
    repeat (4) tick();
    wr(9, 1, 0, 15, 1, 0, 0);
    commit_i = 1; tick(); commit_i = 0;
    n = 6;
    while (busy_o && n < 40) begin n++; tick(); end
    chk(n == 17, "busy_len", n, 17);
    sweep();

    ph = "R10"; // write and commit together
    cfg_we_i = 1; cfg_slot_i = 4'd9; cfg_used_i = 1; cfg_file_i = 0; cfg_key_i = 5'd15;
    cfg_vec_i = 1; cfg_packed_i = 0; cfg_bank_i = 2'd0; commit_i = 1;
    tick();
    cfg_we_i = 0; commit_i = 0;
    while (m_busy) tick();
    lk_file_i = 0; lk_reg_i = 5'd15; tick();
    chk(lk_enabled_o == 1'b1, "new_slot_en", lk_enabled_o, 1);
    sweep();

    ph = "R6";
    wr(10, 1, 0, 16, 1, 1, 1);
    wr(11, 1, 1, 17, 0, 0, 3);
    commit_and_wait(); sweep();
    chk(bank_err_o == 1'b1, "err_set", bank_err_o, 1);
    wr(10, 0, 0, 16, 0, 0, 0);
    wr(11, 0, 0, 17, 0, 0, 0);
    commit_and_wait(); sweep();
    chk(bank_err_o == 1'b1, "err_sticky", bank_err_o, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule